// File: doc/BRIEF.md
# Base Integer Instruction Decoder

This block turns one 32-bit base-integer instruction word into the control bundle that a single-cycle datapath needs. The bundle holds the three register indices, a sign-extended 32-bit immediate built in the right format, an ALU operation code, the second-operand source, the register write enable, the load and store enables, the width/condition field, a writeback source, branch and jump flags, a flag that tells a register-based jump from a PC-relative one, and a halt request raised by the breakpoint instruction.

The decode is combinational, and every output is then captured in a register. An output therefore reflects the word presented before the previous rising clock edge. A synchronous active-high reset clears every output. Words that match no recognised encoding leave every side-effecting control inactive. Fence, fence-instruction and environment-call encodings are accepted as no-operations.

Top module: `rv_instr_decoder`

## Requirements
- R1: Every output is registered, so outputs follow the word sampled at the previous rising edge. While `rst` is high at an edge, all outputs become zero.
- R2: `src1_idx` = bits 19:15, `src2_idx` = bits 24:20, `dst_idx` = bits 11:7 and `sub_fn` = bits 14:12 of the word, for every word.
- R3: `imm_val` depends on the format.
  - I-type: bits 31:20, sign-extended.
  - S-type: bits {31:25, 11:7}, sign-extended.
  - B-type: {31, 7, 30:25, 11:8, 0}, sign-extended.
  - U-type: bits 31:12 followed by twelve zeros.
  - J-type: {31, 19:12, 20, 30:21, 0}, sign-extended.
  - It is zero for words that carry no immediate and for unrecognised words.
- R4: `opb_is_imm` is 1 (select immediate) for loads, stores, register-immediate arithmetic, JALR, LUI, AUIPC and JAL. It is 0 (select second register) for register-register arithmetic and branches.
- R5: `alu_sel` encoding: 0 add, 1 sub, 2 shift-left, 3 set-less-signed, 4 set-less-unsigned, 5 xor, 6 shift-right-logical, 7 shift-right-arithmetic, 8 or, 9 and, 10 pass operand B (LUI), 11 add to PC (AUIPC). Loads, stores and jumps use 0.
- R6: Branches (opcode 1100011) raise `is_branch` only for condition field 000, 001, 100, 101, 110 or 111. `alu_sel` is 1 for 000/001, 3 for 100/101 and 4 for 110/111. Condition fields 010 and 011 are unrecognised.
- R7: `wb_src` is 0 for ALU results, 1 for loads (with `ld_en`=1) and 2 for JAL/JALR link values.
- R8: `is_jump` is 1 for both JAL and JALR. `jump_reg` is 1 only for JALR, whose condition field must be 000.
- R9: `halt_req` is 1 only for the word 0x00100073.
- R10: `rf_we` is 0 for stores and branches, and whenever `dst_idx` is 0.
- R11: An unrecognised word drives `rf_we`, `ld_en`, `st_en`, `is_branch`, `is_jump`, `jump_reg` and `halt_req` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 32 | Instruction word to decode |
| src1_idx | output | 5 | First source register index |
| src2_idx | output | 5 | Second source register index |
| dst_idx | output | 5 | Destination register index |
| sub_fn | output | 3 | Width / condition field |
| imm_val | output | 32 | Sign-extended immediate |
| alu_sel | output | 4 | ALU operation code |
| opb_is_imm | output | 1 | ALU B source: 1 immediate, 0 register |
| rf_we | output | 1 | Register write enable |
| ld_en | output | 1 | Data memory read enable |
| st_en | output | 1 | Data memory write enable |
| wb_src | output | 2 | Writeback source select |
| is_branch | output | 1 | Conditional branch |
| is_jump | output | 1 | Unconditional jump |
| jump_reg | output | 1 | Jump target is register based |
| halt_req | output | 1 | Breakpoint halt request |

## Verification
The hardest cases to reach are legal opcodes that carry an illegal function field. Examples are the reserved branch conditions, shift-immediates with a non-zero upper field, register-register words whose upper field is neither 0 nor 0100000, and JALR with a non-zero condition field. Fully random words almost never produce these. The stimulus therefore first picks one of the valid major opcodes. It then biases the upper field toward the two legal values while still letting stray values through. Directed words cover the breakpoint, the environment call, the reserved branch conditions and writes to register zero.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;
  localparam int XLEN = 32;
  localparam int RIDX_W = 5;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OPREG  = 7'b0110011;
  localparam logic [6:0] OPC_FENCE  = 7'b0001111;
  localparam logic [6:0] OPC_SYS    = 7'b1110011;

  localparam logic [31:0] WORD_BRK  = 32'h0010_0073;
  localparam logic [31:0] WORD_ECL  = 32'h0000_0073;

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_SLL = 4'd2, ALU_SLT = 4'd3,
    ALU_SLTU = 4'd4, ALU_XOR = 4'd5, ALU_SRL = 4'd6, ALU_SRA = 4'd7,
    ALU_OR = 4'd8, ALU_AND = 4'd9, ALU_PASSB = 4'd10, ALU_PCADD = 4'd11
  } alu_op_e;

  typedef enum logic [2:0] {
    FMT_NONE, FMT_I, FMT_S, FMT_B, FMT_U, FMT_J
  } imm_fmt_e;

  typedef enum logic [1:0] {
    WB_ALU = 2'd0, WB_MEM = 2'd1, WB_LINK = 2'd2
  } wb_sel_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    opb_imm;
    logic    rf_we;
    logic    ld;
    logic    st;
    logic    br;
    logic    jmp;
    logic    jreg;
    logic    halt;
    wb_sel_e wb;
  } ctrl_t;

  function automatic alu_op_e f3_to_alu(input logic [2:0] f3, input logic alt);
    case (f3)
      3'd0: return alt ? ALU_SUB : ALU_ADD;
      3'd1: return ALU_SLL;
      3'd2: return ALU_SLT;
      3'd3: return ALU_SLTU;
      3'd4: return ALU_XOR;
      3'd5: return alt ? ALU_SRA : ALU_SRL;
      3'd6: return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction
endpackage

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
  import rvdec_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic [IW-1:0] word,
  output ctrl_t         ctrl,
  output imm_fmt_e      fmt
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic       rd_zero;
  logic       f7_zero, f7_alt;

  assign opc     = word[6:0];
  assign f3      = word[14:12];
  assign f7      = word[31:25];
  assign rd_zero = (word[11:7] == '0);
  assign f7_zero = (f7 == 7'b0000000);
  assign f7_alt  = (f7 == 7'b0100000);

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    ctrl.wb     = WB_ALU;
    fmt         = FMT_NONE;
    case (opc)
      OPC_LUI: begin
        fmt = FMT_U; ctrl.alu_op = ALU_PASSB; ctrl.opb_imm = 1'b1; ctrl.rf_we = 1'b1;
      end
      OPC_AUIPC: begin
        fmt = FMT_U; ctrl.alu_op = ALU_PCADD; ctrl.opb_imm = 1'b1; ctrl.rf_we = 1'b1;
      end
      OPC_JAL: begin
        fmt = FMT_J; ctrl.opb_imm = 1'b1; ctrl.rf_we = 1'b1;
        ctrl.wb = WB_LINK; ctrl.jmp = 1'b1;
      end
      OPC_JALR: begin
        if (f3 == 3'd0) begin
          fmt = FMT_I; ctrl.opb_imm = 1'b1; ctrl.rf_we = 1'b1;
          ctrl.wb = WB_LINK; ctrl.jmp = 1'b1; ctrl.jreg = 1'b1;
        end
      end
      OPC_BRANCH: begin
        if (f3[2:1] != 2'b01) begin
          fmt = FMT_B; ctrl.br = 1'b1;
          case (f3[2:1])
            2'b00:   ctrl.alu_op = ALU_SUB;
            2'b10:   ctrl.alu_op = ALU_SLT;
            default: ctrl.alu_op = ALU_SLTU;
          endcase
        end
      end
      OPC_LOAD: begin
        if (f3 == 3'd0 || f3 == 3'd1 || f3 == 3'd2 || f3 == 3'd4 || f3 == 3'd5) begin
          fmt = FMT_I; ctrl.opb_imm = 1'b1; ctrl.rf_we = 1'b1;
          ctrl.ld = 1'b1; ctrl.wb = WB_MEM;
        end
      end
      OPC_STORE: begin
        if (f3 <= 3'd2) begin
          fmt = FMT_S; ctrl.opb_imm = 1'b1; ctrl.st = 1'b1;
        end
      end
      OPC_OPIMM: begin
        if ((f3 != 3'd1 && f3 != 3'd5) || f7_zero || (f3 == 3'd5 && f7_alt)) begin
          fmt = FMT_I; ctrl.opb_imm = 1'b1; ctrl.rf_we = 1'b1;
          ctrl.alu_op = f3_to_alu(f3, (f3 == 3'd5) && f7_alt);
        end
      end
      OPC_OPREG: begin
        if (f7_zero || (f7_alt && (f3 == 3'd0 || f3 == 3'd5))) begin
          ctrl.rf_we = 1'b1;
          ctrl.alu_op = f3_to_alu(f3, f7_alt);
        end
      end
      OPC_SYS: begin
        if (word == WORD_BRK) ctrl.halt = 1'b1;
      end
      default: ;
    endcase
    if (rd_zero) ctrl.rf_we = 1'b0;
  end
endmodule

// File: rtl/rvdec_immgen.sv
module rvdec_immgen
  import rvdec_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic [IW-1:0] word,
  input  imm_fmt_e      fmt,
  output logic [IW-1:0] imm
);
  localparam int SXW = IW - 12;
  logic sgn;
  assign sgn = word[IW-1];

  always_comb begin
    case (fmt)
      FMT_I: imm = {{SXW{sgn}}, word[31:20]};
      FMT_S: imm = {{SXW{sgn}}, word[31:25], word[11:7]};
      FMT_B: imm = {{(IW-12){sgn}}, word[7], word[30:25], word[11:8], 1'b0};
      FMT_U: imm = {word[31:12], 12'b0};
      FMT_J: imm = {{(IW-20){sgn}}, word[19:12], word[20], word[30:21], 1'b0};
      default: imm = '0;
    endcase
  end
endmodule

// File: rtl/rv_instr_decoder.sv
module rv_instr_decoder
  import rvdec_pkg::*;
#(
  parameter int IW  = XLEN,
  parameter int RAW = RIDX_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IW-1:0]  instr_word,
  output logic [RAW-1:0] src1_idx,
  output logic [RAW-1:0] src2_idx,
  output logic [RAW-1:0] dst_idx,
  output logic [2:0]     sub_fn,
  output logic [IW-1:0]  imm_val,
  output logic [3:0]     alu_sel,
  output logic           opb_is_imm,
  output logic           rf_we,
  output logic           ld_en,
  output logic           st_en,
  output logic [1:0]     wb_src,
  output logic           is_branch,
  output logic           is_jump,
  output logic           jump_reg,
  output logic           halt_req
);
  ctrl_t         ctrl_c;
  imm_fmt_e      fmt_c;
  logic [IW-1:0] imm_c;

  rvdec_ctrl #(.IW(IW)) ctrl_i (.word(instr_word), .ctrl(ctrl_c), .fmt(fmt_c));
  rvdec_immgen #(.IW(IW)) imm_i (.word(instr_word), .fmt(fmt_c), .imm(imm_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      src1_idx <= '0; src2_idx <= '0; dst_idx <= '0; sub_fn <= '0;
      imm_val <= '0; alu_sel <= '0; opb_is_imm <= 1'b0; rf_we <= 1'b0;
      ld_en <= 1'b0; st_en <= 1'b0; wb_src <= '0; is_branch <= 1'b0;
      is_jump <= 1'b0; jump_reg <= 1'b0; halt_req <= 1'b0;
    end else begin
      src1_idx   <= instr_word[19:15];
      src2_idx   <= instr_word[24:20];
      dst_idx    <= instr_word[11:7];
      sub_fn     <= instr_word[14:12];
      imm_val    <= imm_c;
      alu_sel    <= ctrl_c.alu_op;
      opb_is_imm <= ctrl_c.opb_imm;
      rf_we      <= ctrl_c.rf_we;
      ld_en      <= ctrl_c.ld;
      st_en      <= ctrl_c.st;
      wb_src     <= ctrl_c.wb;
      is_branch  <= ctrl_c.br;
      is_jump    <= ctrl_c.jmp;
      jump_reg   <= ctrl_c.jreg;
      halt_req   <= ctrl_c.halt;
    end
  end
endmodule

// File: rtl/rv_instr_decoder_chk.sv
module rv_instr_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] dst_idx,
  input logic       opb_is_imm,
  input logic       rf_we,
  input logic       ld_en,
  input logic       st_en,
  input logic [1:0] wb_src,
  input logic       is_branch,
  input logic       is_jump,
  input logic       jump_reg,
  input logic       halt_req
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!rf_we && !ld_en && !st_en && !is_branch && !is_jump && !halt_req));

  a_r10_no_x0_write: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (dst_idx != 5'd0));

  a_r8_jalr_is_jump: assert property (@(posedge clk) disable iff (rst)
    jump_reg |-> (is_jump && wb_src == 2'd2));

  a_r7_load_wb: assert property (@(posedge clk) disable iff (rst)
    ld_en |-> (wb_src == 2'd1 && opb_is_imm && !st_en));

  a_r6_branch_quiet: assert property (@(posedge clk) disable iff (rst)
    is_branch |-> (!rf_we && !ld_en && !st_en && !opb_is_imm && !is_jump));

  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> (!rf_we && !ld_en && !st_en && !is_branch && !is_jump));
endmodule

bind rv_instr_decoder rv_instr_decoder_chk chk_i (
  .clk(clk), .rst(rst), .dst_idx(dst_idx), .opb_is_imm(opb_is_imm),
  .rf_we(rf_we), .ld_en(ld_en), .st_en(st_en), .wb_src(wb_src),
  .is_branch(is_branch), .is_jump(is_jump), .jump_reg(jump_reg),
  .halt_req(halt_req)
);

// File: tb/rv_instr_decoder_tb_top.sv
module rv_instr_decoder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] instr_word = 32'h0;
  logic [4:0] src1_idx, src2_idx, dst_idx;
  logic [2:0] sub_fn;
  logic [31:0] imm_val;
  logic [3:0] alu_sel;
  logic opb_is_imm, rf_we, ld_en, st_en, is_branch, is_jump, jump_reg, halt_req;
  logic [1:0] wb_src;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rv_instr_decoder dut_i (
    .clk(clk), .rst(rst), .instr_word(instr_word),
    .src1_idx(src1_idx), .src2_idx(src2_idx), .dst_idx(dst_idx), .sub_fn(sub_fn),
    .imm_val(imm_val), .alu_sel(alu_sel), .opb_is_imm(opb_is_imm), .rf_we(rf_we),
    .ld_en(ld_en), .st_en(st_en), .wb_src(wb_src), .is_branch(is_branch),
    .is_jump(is_jump), .jump_reg(jump_reg), .halt_req(halt_req)
  );

  typedef struct packed {
    logic [31:0] imm;
    logic [3:0]  alu;
    logic        opb, we, ld, st;
    logic [1:0]  wb;
    logic        br, j, jr, h;
  } exp_t;

  function automatic logic [31:0] sx(input logic [31:0] v, input int top);
    logic [31:0] r;
    for (int k = 0; k < 32; k++) r[k] = (k <= top) ? v[k] : v[top];
    return r;
  endfunction

  function automatic exp_t model(input logic [31:0] w);
    exp_t e;
    logic [6:0] op; logic [2:0] f; logic [6:0] hi;
    logic [31:0] iI, iS, iB, iU, iJ;
    op = w[6:0]; f = w[14:12]; hi = w[31:25];
    iI = sx({20'b0, w[31:20]}, 11);
    iS = sx({20'b0, w[31:25], w[11:7]}, 11);
    iB = sx({19'b0, w[31], w[7], w[30:25], w[11:8], 1'b0}, 12);
    iU = {w[31:12], 12'h000};
    iJ = sx({11'b0, w[31], w[19:12], w[20], w[30:21], 1'b0}, 20);
    e = '0;
    if (op == 7'h37) begin e.imm = iU; e.alu = 4'd10; e.opb = 1; e.we = 1; end
    else if (op == 7'h17) begin e.imm = iU; e.alu = 4'd11; e.opb = 1; e.we = 1; end
    else if (op == 7'h6F) begin e.imm = iJ; e.opb = 1; e.we = 1; e.wb = 2; e.j = 1; end
    else if (op == 7'h67 && f == 0) begin
      e.imm = iI; e.opb = 1; e.we = 1; e.wb = 2; e.j = 1; e.jr = 1;
    end
    else if (op == 7'h63 && f != 2 && f != 3) begin
      e.imm = iB; e.br = 1;
      e.alu = (f < 2) ? 4'd1 : (f < 6) ? 4'd3 : 4'd4;
    end
    else if (op == 7'h03 && (f == 0 || f == 1 || f == 2 || f == 4 || f == 5)) begin
      e.imm = iI; e.opb = 1; e.we = 1; e.ld = 1; e.wb = 1;
    end
    else if (op == 7'h23 && f < 3) begin e.imm = iS; e.opb = 1; e.st = 1; end
    else if (op == 7'h13) begin
      logic ok; logic [3:0] a;
      ok = 1;
      case (f)
        0: a = 0; 2: a = 3; 3: a = 4; 4: a = 5; 6: a = 8; 7: a = 9;
        1: begin a = 2; ok = (hi == 0); end
        default: begin a = (hi == 7'h20) ? 4'd7 : 4'd6; ok = (hi == 0 || hi == 7'h20); end
      endcase
      if (ok) begin e.imm = iI; e.alu = a; e.opb = 1; e.we = 1; end
    end
    else if (op == 7'h33) begin
      logic [3:0] a;
      case (f)
        0: a = (hi == 7'h20) ? 4'd1 : 4'd0; 1: a = 2; 2: a = 3; 3: a = 4;
        4: a = 5; 5: a = (hi == 7'h20) ? 4'd7 : 4'd6; 6: a = 8; default: a = 9;
      endcase
      if (hi == 0 || (hi == 7'h20 && (f == 0 || f == 5))) begin e.alu = a; e.we = 1; end
    end
    else if (w == 32'h0010_0073) e.h = 1;
    if (w[11:7] == 0) e.we = 0;
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input logic [31:0] w);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s word=%08h actual=%0h expected=%0h", req, w, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w);
    exp_t e;
    instr_word = w;
    @(posedge clk); #2;
    e = model(w);
    chk("R2 fields", {9'd0, src1_idx, src2_idx, dst_idx, sub_fn},
        {9'd0, w[19:15], w[24:20], w[11:7], w[14:12]}, w);
    chk("R3 imm", imm_val, e.imm, w);
    chk("R4 opb_is_imm", {31'd0, opb_is_imm}, {31'd0, e.opb}, w);
    chk("R5/R6 alu_sel", {28'd0, alu_sel}, {28'd0, e.alu}, w);
    chk("R7 wb_src/ld_en", {29'd0, wb_src, ld_en}, {29'd0, e.wb, e.ld}, w);
    chk("R6 is_branch", {31'd0, is_branch}, {31'd0, e.br}, w);
    chk("R8 jump flags", {30'd0, is_jump, jump_reg}, {30'd0, e.j, e.jr}, w);
    chk("R9 halt_req", {31'd0, halt_req}, {31'd0, e.h}, w);
    chk("R10/R11 rf_we/st_en", {30'd0, rf_we, st_en}, {30'd0, e.we, e.st}, w);
  endtask

  localparam logic [6:0] OPS [10] = '{7'h37, 7'h17, 7'h6F, 7'h67, 7'h63,
                                      7'h03, 7'h23, 7'h13, 7'h33, 7'h73};

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    instr_word = 32'h0050_0093;
    repeat (2) @(posedge clk);
    #2;
    // R1: reset forces zeros even with a legal word at the input
    chk("R1 reset state", {imm_val[15:0], alu_sel, opb_is_imm, rf_we, ld_en, st_en,
                           wb_src, is_branch, is_jump, jump_reg, halt_req, dst_idx},
        32'd0, instr_word);
    rst = 1'b0;
    // directed corner cases
    run(32'h0010_0073);              // R9 breakpoint
    run(32'h0000_0073);              // ecall: no side effects
    run(32'h0020_8263 | (32'd2 << 12)); // R6 reserved cond 010
    run(32'h0020_B263);              // R6 reserved cond 011
    run(32'h0050_0013);              // R10 addi to x0
    run(32'hFFF0_8093);              // negative I immediate
    run(32'hFE11_AE23);              // negative S immediate
    run(32'hFE20_8EE3);              // negative B immediate
    run(32'h8000_00B7);              // U immediate, top bit set
    run(32'hFFDF_F0EF);              // R8 JAL negative offset
    run(32'h0040_80E7);              // R8 JALR
    run(32'h0040_90E7);              // R8 JALR bad cond -> R11
    run(32'h4020_81B3);              // SUB
    run(32'h2020_81B3);              // R11 bad upper field
    run(32'h4030_D093);              // SRAI
    run(32'h4030_9093);              // R11 SLLI with upper bit
    run(32'h0000_7003);              // R11 bad load width
    run(32'hFFFF_FFFF);              // R11 garbage
    // R1 latency: two different words back to back
    run(32'h0000_0000);
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] w;
      w = $urandom;
      if ((n % 8) != 7) begin
        w[6:0] = OPS[$urandom % 10];
        case ($urandom % 4)
          0: w[31:25] = 7'h00;
          1: w[31:25] = 7'h20;
          default: ;
        endcase
        if (w[6:0] == 7'h73 && ($urandom % 2) == 0) w = (($urandom % 2) == 1) ? 32'h0010_0073 : 32'h0000_0073;
      end
      run(w);
    end
    // R1: reset reasserted mid-run clears outputs again
    instr_word = 32'h0010_0073;
    rst = 1'b1;
    @(posedge clk); #2;
    chk("R1 reset reasserted", {27'd0, halt_req, rf_we, is_jump, ld_en, st_en},
        32'd0, instr_word);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule